// File: doc/BRIEF.md
# Queued Interrupt Message Controller

This block gathers interrupt events from two sources, input changes and overcurrent detection, into a short first-in first-out queue of messages. Each message holds a cause code and a channel mask. The oldest message sits in a status view that software reads. An active-low interrupt line stays asserted for as long as any message waits in the queue.

Software acknowledges a message by writing 1 to the end-of-interrupt bit, which is bit 7 of the filter control register. The bit reads back as 1 for one cycle and then clears itself. On the next clock edge the head message is deleted. The next queued message then moves into the status view. When the queue runs dry, the interrupt line is released instead. Events that find the queue full are dropped and recorded in a sticky overflow flag. Address decoding and event generation happen outside this block. The block sees only the write strobe, the value written to bit 7 and the event strobes.

Top module: `irq_msg_ctrl`

## Requirements
- R1: While reset is held and right after it, `intn` is 1 and `stat_cause`, `stat_mask`, `stat_overflow` and `eoi_flag` are all 0.
- R2: An event with `evt_valid`=1 and a nonzero cause is queued at that clock edge. The cause codes are 2'b01 input change, 2'b10 overcurrent and 2'b11 both. An event with cause 2'b00 is ignored.
- R3: `stat_cause` and `stat_mask` show the oldest queued message, with messages leaving in arrival order. Both are 0 when the queue is empty.
- R4: `intn` is 0 exactly when at least one message is queued. It changes at the same edge as the queue does.
- R5: A write with `ctl_wr`=1 and `ctl_eoi_wbit`=1 sets `eoi_flag` for exactly one cycle. At the following edge the head message is deleted.
- R6: A write with `ctl_eoi_wbit`=0 leaves `eoi_flag` at 0 and changes no message.
- R7: An acknowledge while the queue is empty has no effect: there is no underflow and later events are queued normally.
- R8: An event that arrives while all DEPTH entries are full is discarded and sets `stat_overflow`. The flag stays set until reset.
- R9: When an event arrives at the same edge where an acknowledge deletes the head, both take place and the occupancy stays the same. This holds even when the queue is full, and no overflow is flagged.
- R10: Back-to-back acknowledge writes on consecutive cycles each delete one message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_valid | input | 1 | Event strobe, one message per cycle |
| evt_cause | input | 2 | Cause code of the event |
| evt_mask | input | MASK_W | Channels involved in the event |
| ctl_wr | input | 1 | Write strobe of the filter control register |
| ctl_eoi_wbit | input | 1 | Value written to bit 7 of that register |
| eoi_flag | output | 1 | Read-back of the self-clearing acknowledge bit |
| stat_cause | output | 2 | Cause of the oldest message, 0 when empty |
| stat_mask | output | MASK_W | Mask of the oldest message, 0 when empty |
| stat_overflow | output | 1 | Sticky flag for a dropped event |
| intn | output | 1 | Active-low interrupt request |

## Verification
The bench builds the block with its defaults, DEPTH=4 and MASK_W=8. With only four entries, a full queue is reached after a handful of events. That puts overflow, and a push coinciding with a pop on a full queue, within a few dozen cycles. The 8-bit mask lets each message carry a distinct pattern, so any reordering or stale head shows up in the status view.

// File: rtl/irq_msg_pkg.sv
package irq_msg_pkg;

  typedef enum logic [1:0] {
    CAUSE_NONE = 2'b00,
    CAUSE_CHG  = 2'b01,
    CAUSE_OVC  = 2'b10,
    CAUSE_BOTH = 2'b11
  } irq_cause_e;

  // circular pointer advance for an arbitrary depth
  function automatic int ptr_step(input int p, input int depth);
    return (p == depth - 1) ? 0 : p + 1;
  endfunction

  // occupancy after one edge with the given push / pop decisions
  function automatic int lvl_step(input int lvl, input logic push, input logic pop);
    int n;
    n = lvl;
    if (push) n = n + 1;
    if (pop)  n = n - 1;
    return n;
  endfunction

  // a queued event must carry a real cause
  function automatic logic cause_valid(input logic [1:0] c);
    return c != CAUSE_NONE;
  endfunction

endpackage

// File: rtl/irq_eoi_reg.sv
module irq_eoi_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic ctl_wr,
  input  logic ctl_eoi_wbit,
  output logic eoi_q
);
  // self-clearing: holds a written 1 for exactly one cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) eoi_q <= 1'b0;
    else        eoi_q <= ctl_wr & ctl_eoi_wbit;
  end
endmodule

// File: rtl/irq_msg_admit.sv
module irq_msg_admit
  import irq_msg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       evt_valid,
  input  logic [1:0] evt_cause,
  input  logic       full,
  input  logic       pop,
  output logic       push_req,
  output logic       push_acc,
  output logic       ovf_evt,
  output logic       ovf_sticky
);
  always_comb begin
    push_req = evt_valid & cause_valid(evt_cause);
    // a pop on the same edge frees the slot the push needs
    push_acc = push_req & (~full | pop);
    ovf_evt  = push_req & full & ~pop;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ovf_sticky <= 1'b0;
    else if (ovf_evt) ovf_sticky <= 1'b1;
  end
endmodule

// File: rtl/irq_msg_fifo.sv
module irq_msg_fifo
  import irq_msg_pkg::*;
#(
  parameter int DEPTH   = 4,
  parameter int ENTRY_W = 10,
  localparam int PTR_W  = $clog2(DEPTH),
  localparam int LVL_W  = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               push,
  input  logic [ENTRY_W-1:0] push_data,
  input  logic               pop,
  output logic [ENTRY_W-1:0] head_data,
  output logic               empty,
  output logic               full,
  output logic [LVL_W-1:0]   level
);
  logic [ENTRY_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]   wr_ptr, rd_ptr;

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (push) wr_ptr <= PTR_W'(ptr_step(int'(wr_ptr), DEPTH));
      if (pop)  rd_ptr <= PTR_W'(ptr_step(int'(rd_ptr), DEPTH));
      level <= LVL_W'(lvl_step(int'(level), push, pop));
    end
  end

  always_comb begin
    empty     = (level == '0);
    full      = (level == LVL_W'(DEPTH));
    head_data = mem[rd_ptr];
  end
endmodule

// File: rtl/irq_msg_ctrl.sv
module irq_msg_ctrl
  import irq_msg_pkg::*;
#(
  parameter int DEPTH  = 4,
  parameter int MASK_W = 8,
  localparam int ENTRY_W = MASK_W + 2,
  localparam int LVL_W   = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_valid,
  input  logic [1:0]        evt_cause,
  input  logic [MASK_W-1:0] evt_mask,
  input  logic              ctl_wr,
  input  logic              ctl_eoi_wbit,
  output logic              eoi_flag,
  output logic [1:0]        stat_cause,
  output logic [MASK_W-1:0] stat_mask,
  output logic              stat_overflow,
  output logic              intn
);
  // named internal events, brought out for the checker
  logic               push_req_w, push_acc_w, pop_w, ovf_evt_w;
  logic               empty_w, full_w;
  logic [LVL_W-1:0]   level_w;
  logic [ENTRY_W-1:0] head_w;

  irq_eoi_reg u_eoi (
    .clk          (clk),
    .rst_n        (rst_n),
    .ctl_wr       (ctl_wr),
    .ctl_eoi_wbit (ctl_eoi_wbit),
    .eoi_q        (eoi_flag)
  );

  // acknowledge deletes the head only when one exists
  assign pop_w = eoi_flag & ~empty_w;

  irq_msg_admit u_admit (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt_valid  (evt_valid),
    .evt_cause  (evt_cause),
    .full       (full_w),
    .pop        (pop_w),
    .push_req   (push_req_w),
    .push_acc   (push_acc_w),
    .ovf_evt    (ovf_evt_w),
    .ovf_sticky (stat_overflow)
  );

  irq_msg_fifo #(.DEPTH(DEPTH), .ENTRY_W(ENTRY_W)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push_acc_w),
    .push_data ({evt_cause, evt_mask}),
    .pop       (pop_w),
    .head_data (head_w),
    .empty     (empty_w),
    .full      (full_w),
    .level     (level_w)
  );

  always_comb begin
    if (empty_w) begin
      stat_cause = CAUSE_NONE;
      stat_mask  = '0;
    end else begin
      stat_cause = head_w[ENTRY_W-1 -: 2];
      stat_mask  = head_w[MASK_W-1:0];
    end
    intn = empty_w;
  end
endmodule

// File: rtl/irq_msg_ctrl_chk.sv
module irq_msg_ctrl_chk #(
  parameter int LVL_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ctl_wr,
  input logic             ctl_eoi_wbit,
  input logic             eoi_flag,
  input logic             intn,
  input logic [1:0]       stat_cause,
  input logic             stat_overflow,
  input logic             push_req_w,
  input logic             push_acc_w,
  input logic             pop_w,
  input logic             full_w,
  input logic [LVL_W-1:0] level_w
);
  assert_push_grows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (push_acc_w && !pop_w) |=> (level_w == $past(level_w) + 1'b1));

  assert_intn_matches_status_R4: assert property (@(posedge clk) disable iff (!rst_n)
    intn == (stat_cause == 2'b00));

  assert_eoi_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && ctl_eoi_wbit) |=> eoi_flag);

  assert_eoi_selfclear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctl_wr && ctl_eoi_wbit) |=> !eoi_flag);

  assert_empty_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_flag && level_w == '0 && !push_acc_w) |=> (level_w == '0));

  assert_overflow_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stat_overflow |=> stat_overflow);

  assert_overflow_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_overflow) |-> $past(push_req_w && full_w && !pop_w));

  assert_swap_level_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (push_acc_w && pop_w) |=> $stable(level_w));
endmodule

bind irq_msg_ctrl irq_msg_ctrl_chk #(.LVL_W(LVL_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .ctl_wr        (ctl_wr),
  .ctl_eoi_wbit  (ctl_eoi_wbit),
  .eoi_flag      (eoi_flag),
  .intn          (intn),
  .stat_cause    (stat_cause),
  .stat_overflow (stat_overflow),
  .push_req_w    (push_req_w),
  .push_acc_w    (push_acc_w),
  .pop_w         (pop_w),
  .full_w        (full_w),
  .level_w       (level_w)
);

// File: tb/tb_irq_msg_ctrl.sv
module tb_irq_msg_ctrl;
  localparam int DEPTH  = 4;
  localparam int MASK_W = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              evt_valid = 1'b0;
  logic [1:0]        evt_cause = 2'b00;
  logic [MASK_W-1:0] evt_mask = '0;
  logic              ctl_wr = 1'b0;
  logic              ctl_eoi_wbit = 1'b0;
  logic              eoi_flag, stat_overflow, intn;
  logic [1:0]        stat_cause;
  logic [MASK_W-1:0] stat_mask;

  irq_msg_ctrl #(.DEPTH(DEPTH), .MASK_W(MASK_W)) dut (
    .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_cause(evt_cause),
    .evt_mask(evt_mask), .ctl_wr(ctl_wr), .ctl_eoi_wbit(ctl_eoi_wbit),
    .eoi_flag(eoi_flag), .stat_cause(stat_cause), .stat_mask(stat_mask),
    .stat_overflow(stat_overflow), .intn(intn)
  );

  always #10 clk = ~clk;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;
  bit mon_on = 1'b0;

  // scoreboard state: expected messages, as {cause, mask}
  logic [MASK_W+1:0] exp_q[$];
  bit exp_ovf = 1'b0;
  bit exp_eoi = 1'b0;
  string phase = "R3";

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // driver: applies one cycle of stimulus and updates the expectation
  task automatic step(input bit v, input logic [1:0] c, input logic [7:0] m,
                      input bit wr, input bit b);
    bit pop, req;
    @(negedge clk);
    evt_valid = v; evt_cause = c; evt_mask = m; ctl_wr = wr; ctl_eoi_wbit = b;
    @(posedge clk);
    pop = exp_eoi && (exp_q.size() > 0);
    req = v && (c != 2'b00);
    if (req && exp_q.size() == DEPTH && !pop) exp_ovf = 1'b1;
    else if (req) exp_q.push_back({c, m});
    if (pop) void'(exp_q.pop_front());
    exp_eoi = wr && b;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 2'b00, 8'h00, 0, 0);
  endtask

  task automatic ack();
    step(0, 2'b00, 8'h00, 1, 1);
  endtask

  // monitor: compares the design against the head of the expected queue
  always @(posedge clk) begin
    #5;
    if (mon_on) begin
      chk({phase, "/R4 intn"}, 32'(intn), 32'(exp_q.size() == 0));
      chk({phase, "/R3 cause"}, 32'(stat_cause),
          exp_q.size() ? 32'(exp_q[0][MASK_W+1:MASK_W]) : 32'd0);
      chk({phase, "/R3 mask"}, 32'(stat_mask),
          exp_q.size() ? 32'(exp_q[0][MASK_W-1:0]) : 32'd0);
      chk({phase, "/R8 ovf"}, 32'(stat_overflow), 32'(exp_ovf));
      chk({phase, "/R5 eoi"}, 32'(eoi_flag), 32'(exp_eoi));
    end
  end

  task automatic do_reset();
    mon_on = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    evt_valid = 0; ctl_wr = 0; ctl_eoi_wbit = 0;
    exp_q.delete(); exp_ovf = 0; exp_eoi = 0;
    @(negedge clk);
    chk("R1 intn", 32'(intn), 32'd1);
    chk("R1 cause", 32'(stat_cause), 32'd0);
    chk("R1 mask", 32'(stat_mask), 32'd0);
    chk("R1 ovf", 32'(stat_overflow), 32'd0);
    chk("R1 eoi", 32'(eoi_flag), 32'd0);
    rst_n = 1'b1;
    mon_on = 1'b1;
  endtask

  initial begin
    do_reset();
    idle(1);

    phase = "R2";
    step(1, 2'b01, 8'hA5, 0, 0);
    step(1, 2'b00, 8'hFF, 0, 0);     // null cause ignored
    step(1, 2'b10, 8'h3C, 0, 0);
    step(1, 2'b11, 8'h81, 0, 0);
    idle(1);
    chk("R2 head kept", 32'(stat_mask), 32'hA5);

    phase = "R6";
    step(0, 2'b00, 8'h00, 1, 0);
    step(0, 2'b00, 8'h00, 1, 0);
    idle(1);
    chk("R6 no delete", 32'(stat_mask), 32'hA5);

    phase = "R5";
    ack();
    idle(2);
    chk("R5 next head", 32'(stat_mask), 32'h3C);

    phase = "R10";
    ack(); ack();
    idle(2);
    chk("R10 two deleted", 32'(intn), 32'd1);

    phase = "R7";
    ack(); ack();
    idle(2);
    step(1, 2'b10, 8'h42, 0, 0);
    idle(1);
    chk("R7 event after empty ack", 32'(stat_mask), 32'h42);

    phase = "R9";
    step(1, 2'b01, 8'h11, 0, 0);
    step(1, 2'b10, 8'h22, 0, 0);
    step(1, 2'b11, 8'h33, 1, 1);     // queue full now, ack armed
    step(1, 2'b01, 8'h44, 0, 0);     // push meets pop at full
    idle(1);
    chk("R9 no overflow", 32'(stat_overflow), 32'd0);
    chk("R9 head advanced", 32'(stat_mask), 32'h11);

    phase = "R8";
    step(1, 2'b10, 8'h55, 0, 0);     // full, dropped
    idle(2);
    chk("R8 overflow set", 32'(stat_overflow), 32'd1);
    for (int i = 0; i < 5; i++) begin ack(); idle(1); end
    idle(1);
    chk("R8 overflow sticky", 32'(stat_overflow), 32'd1);
    chk("R8 drained", 32'(intn), 32'd1);

    do_reset();
    idle(2);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule